// File: doc/BRIEF.md
# Processor debug event recorder

This block gathers the debug events of a small processor core into one sticky status register and decides whether a debug interrupt should be raised. It takes five kinds of event. The first is a return-from-critical-interrupt instruction being attempted, which arrives with its program counter. The other four are two external event pins, an unconditional event pin with no enable, and a performance-monitor pulse gated by its own enable. Every event is recorded whether or not debug interrupts are globally enabled.

Software reaches the block through a simple write port. It can load the debug control register, which holds the per-event enables. It can load the performance control register, which holds the monitor enable. It can clear status bits by writing ones. An external debugger can take ownership of either control register, and software writes to an owned register are dropped without any error. A critical return seen while interrupts are off also marks the event as imprecise. A critical return seen while interrupts are on stores the instruction's address for the interrupt handler.

Top module: `dbg_event_recorder`

## Requirements
- R1: After reset the status register, the interrupt request and the saved address are all zero.
- R2: A critical-return pulse sets status bit 0 on the next clock edge only if debug control bit 0 is 1. With that bit at 0 the pulse leaves status unchanged.
- R3: A recorded critical return with the global debug enable at 0 also sets the imprecise bit (status bit 3). With the enable at 1 it leaves that bit alone.
- R4: A recorded critical return with the global debug enable at 1 loads the saved address with that cycle's program counter on the next edge. The saved address changes at no other time.
- R5: External pin i (i = 0, 1) is passed through a two-flop synchronizer. A 0-to-1 transition sets status bit 4+i on the third clock edge after the pin rises, if debug control bit 1+i is 1 and the CPU-stopped input is 0 on that edge. A pin held high does not fire again.
- R6: A 0-to-1 transition of the unconditional pin sets status bit 1 with the same three-edge latency, whatever the control registers hold.
- R7: A performance-monitor pulse sets status bit 2 on the next edge only if performance control bit 0 is 1. The debug control bits do not affect it.
- R8: Writing select 2 clears every status bit whose data bit is 1. When an event sets a bit in the same cycle as a clear, the bit ends up set.
- R9: While external debug mode is 1, a software write to the debug control register (select 0) is ignored if ownership bit 0 is 0. A write to the performance control register (select 1) is ignored if ownership bit 1 is 0. Status writes are always accepted.
- R10: The interrupt request is 1 exactly when the global debug enable is 1, no higher-priority exception is pending, and some status bit is set whose event is enabled. The unconditional bit always counts and the imprecise bit never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_en | input | 1 | Global debug interrupt enable |
| hi_pri_pend | input | 1 | A higher-priority enabled exception is pending |
| cret_exec | input | 1 | Return-from-critical-interrupt instruction attempted this cycle |
| cret_pc | input | PC_W | Address of that instruction |
| ext_evt_pin | input | N_EXT | External debug event pins, asynchronous |
| ude_pin | input | 1 | Unconditional debug event pin, asynchronous |
| pm_event | input | 1 | Performance-monitor interrupt pulse |
| cpu_stopped | input | 1 | CPU is in the stopped state |
| ext_dbg_mode | input | 1 | External debugger mode active |
| own_mask | input | 2 | Software ownership: bit 0 debug control, bit 1 performance control |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 2 | Write target: 0 debug control, 1 performance control, 2 status clear, 3 none |
| wr_data | input | STAT_W | Write data |
| status | output | STAT_W | Sticky event status |
| irq | output | 1 | Debug interrupt request |
| saved_pc | output | PC_W | Saved critical-return address |

## Verification
The bench targets a critical return taken with interrupts off. A design that mixed up the enable would set no imprecise bit, or would overwrite the saved address. It checks that a pin held high records only once, since a level detector would set the bit again after every clear. It also checks that an edge arriving while the CPU is stopped is lost for good, and that a clear issued in the same cycle as a monitor event leaves the bit set, which a clear-first design would get wrong. Finally, it makes software writes while the debugger owns a register, where a design missing the ownership gate would start recording events that should stay masked.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

   // status bit positions
   localparam int BIT_CRT  = 0;
   localparam int BIT_UDE  = 1;
   localparam int BIT_PMI  = 2;
   localparam int BIT_IMP  = 3;
   localparam int EXT_BASE = 4;

   // debug control register layout
   localparam int CTL_CRT_EN  = 0;
   localparam int CTL_EXT_EN0 = 1;

   // ownership mask positions
   localparam int OWN_DBGCTL = 0;
   localparam int OWN_PMCTL  = 1;
   localparam int OWN_W      = 2;

   typedef enum logic [1:0] {
      SEL_DBGCTL = 2'd0,
      SEL_PMCTL  = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_NONE   = 2'd3
   } wr_sel_e;

endpackage

// File: rtl/dbg_pin_edge.sv
module dbg_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbg_pin_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
   import dbg_evt_pkg::*;
#(
   parameter int CTL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CTL_W-1:0] wr_data,
   input  logic             ext_dbg_mode,
   input  logic [OWN_W-1:0] own_mask,
   output logic [CTL_W-1:0] dbg_ctl_q,
   output logic             pm_en_q
);

   generate
      if (CTL_W < 1) begin : g_bad_ctl
         $error("dbg_ctl_regs: CTL_W must be positive");
      end
   endgenerate

   // software may write a resource unless the debugger holds it
   logic [OWN_W-1:0] sw_may;
   assign sw_may = ext_dbg_mode ? own_mask : {OWN_W{1'b1}};

   logic dbgctl_we;
   logic pmctl_we;
   assign dbgctl_we = wr_en && (wr_sel == SEL_DBGCTL) && sw_may[OWN_DBGCTL];
   assign pmctl_we  = wr_en && (wr_sel == SEL_PMCTL)  && sw_may[OWN_PMCTL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbg_ctl_q <= '0;
      end else if (dbgctl_we) begin
         dbg_ctl_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_en_q <= 1'b0;
      end else if (pmctl_we) begin
         pm_en_q <= wr_data[0];
      end
   end

endmodule

// File: rtl/dbg_status_core.sv
module dbg_status_core
   import dbg_evt_pkg::*;
#(
   parameter int N_EXT  = 2,
   parameter int PC_W   = 32,
   parameter int STAT_W = EXT_BASE + N_EXT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              crt_fire,
   input  logic              imp_fire,
   input  logic              ude_fire,
   input  logic              pmi_fire,
   input  logic [N_EXT-1:0]  ext_fire,
   input  logic              load_pc,
   input  logic [PC_W-1:0]   pc_in,
   input  logic              clr_en,
   input  logic [STAT_W-1:0] clr_mask,
   input  logic [STAT_W-1:0] irq_mask,
   input  logic              dbg_en,
   input  logic              hi_pri_pend,
   output logic [STAT_W-1:0] status_q,
   output logic [PC_W-1:0]   saved_pc_q,
   output logic              irq
);

   generate
      if (STAT_W != EXT_BASE + N_EXT) begin : g_bad_w
         $error("dbg_status_core: STAT_W does not match N_EXT");
      end
   endgenerate

   logic [STAT_W-1:0] set_vec;

   always_comb begin
      set_vec           = '0;
      set_vec[BIT_CRT]  = crt_fire;
      set_vec[BIT_UDE]  = ude_fire;
      set_vec[BIT_PMI]  = pmi_fire;
      set_vec[BIT_IMP]  = imp_fire;
      set_vec[STAT_W-1:EXT_BASE] = ext_fire;
   end

   logic [STAT_W-1:0] keep_vec;
   assign keep_vec = clr_en ? (status_q & ~clr_mask) : status_q;

   // set after clear: an event arriving with a clear survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         status_q <= keep_vec | set_vec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saved_pc_q <= '0;
      end else if (load_pc) begin
         saved_pc_q <= pc_in;
      end
   end

   assign irq = dbg_en & ~hi_pri_pend & (|(status_q & irq_mask));

endmodule

// File: rtl/dbg_event_recorder.sv
module dbg_event_recorder
   import dbg_evt_pkg::*;
#(
   parameter  int N_EXT       = 2,
   parameter  int PC_W        = 32,
   parameter  int SYNC_STAGES = 2,
   localparam int STAT_W      = EXT_BASE + N_EXT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_en,
   input  logic              hi_pri_pend,
   input  logic              cret_exec,
   input  logic [PC_W-1:0]   cret_pc,
   input  logic [N_EXT-1:0]  ext_evt_pin,
   input  logic              ude_pin,
   input  logic              pm_event,
   input  logic              cpu_stopped,
   input  logic              ext_dbg_mode,
   input  logic [OWN_W-1:0]  own_mask,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [STAT_W-1:0] wr_data,
   output logic [STAT_W-1:0] status,
   output logic              irq,
   output logic [PC_W-1:0]   saved_pc
);

   localparam int CTL_W = CTL_EXT_EN0 + N_EXT;

   generate
      if (N_EXT < 1) begin : g_bad_next
         $error("dbg_event_recorder: N_EXT must be at least 1");
      end
      if (PC_W < 2) begin : g_bad_pcw
         $error("dbg_event_recorder: PC_W too small");
      end
   endgenerate

   // control registers
   logic [CTL_W-1:0] dbg_ctl_q;
   logic             pm_en_q;

   dbg_ctl_regs #(
      .CTL_W (CTL_W)
   ) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data[CTL_W-1:0]),
      .ext_dbg_mode (ext_dbg_mode),
      .own_mask     (own_mask),
      .dbg_ctl_q    (dbg_ctl_q),
      .pm_en_q      (pm_en_q)
   );

   // asynchronous pins: synchronize then detect rising edge
   logic [N_EXT-1:0] ext_rise;
   logic [N_EXT-1:0] ext_fire;
   logic             ude_rise;

   generate
      for (genvar gi = 0; gi < N_EXT; gi++) begin : g_ext
         dbg_pin_edge #(
            .STAGES (SYNC_STAGES)
         ) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_evt_pin[gi]),
            .rise  (ext_rise[gi])
         );
         assign ext_fire[gi] = ext_rise[gi] & dbg_ctl_q[CTL_EXT_EN0+gi] & ~cpu_stopped;
      end
   endgenerate

   dbg_pin_edge #(
      .STAGES (SYNC_STAGES)
   ) u_ude_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ude_pin),
      .rise  (ude_rise)
   );

   // synchronous events
   logic crt_fire;
   logic imp_fire;
   logic load_pc;
   logic pmi_fire;

   assign crt_fire = cret_exec & dbg_ctl_q[CTL_CRT_EN];
   assign imp_fire = crt_fire & ~dbg_en;
   assign load_pc  = crt_fire & dbg_en;
   assign pmi_fire = pm_event & pm_en_q;

   // which status bits may drive the interrupt
   logic [STAT_W-1:0] irq_mask;

   always_comb begin
      irq_mask          = '0;
      irq_mask[BIT_CRT] = dbg_ctl_q[CTL_CRT_EN];
      irq_mask[BIT_UDE] = 1'b1;
      irq_mask[BIT_PMI] = pm_en_q;
      irq_mask[BIT_IMP] = 1'b0;
      irq_mask[STAT_W-1:EXT_BASE] = dbg_ctl_q[CTL_W-1:CTL_EXT_EN0];
   end

   logic status_clr;
   assign status_clr = wr_en && (wr_sel == SEL_STATUS);

   dbg_status_core #(
      .N_EXT  (N_EXT),
      .PC_W   (PC_W),
      .STAT_W (STAT_W)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .crt_fire    (crt_fire),
      .imp_fire    (imp_fire),
      .ude_fire    (ude_rise),
      .pmi_fire    (pmi_fire),
      .ext_fire    (ext_fire),
      .load_pc     (load_pc),
      .pc_in       (cret_pc),
      .clr_en      (status_clr),
      .clr_mask    (wr_data),
      .irq_mask    (irq_mask),
      .dbg_en      (dbg_en),
      .hi_pri_pend (hi_pri_pend),
      .status_q    (status),
      .saved_pc_q  (saved_pc),
      .irq         (irq)
   );

endmodule

// File: rtl/dbg_event_recorder_chk.sv
module dbg_event_recorder_chk
   import dbg_evt_pkg::*;
#(
   parameter int N_EXT  = 2,
   parameter int PC_W   = 32,
   parameter int STAT_W = EXT_BASE + N_EXT,
   parameter int CTL_W  = CTL_EXT_EN0 + N_EXT
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbg_en,
   input logic              hi_pri_pend,
   input logic              cret_exec,
   input logic [PC_W-1:0]   cret_pc,
   input logic              pm_event,
   input logic              ext_dbg_mode,
   input logic [OWN_W-1:0]  own_mask,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [STAT_W-1:0] status,
   input logic              irq,
   input logic [PC_W-1:0]   saved_pc,
   input logic [CTL_W-1:0]  dbg_ctl_q,
   input logic              pm_en_q
);

   // R1: held in reset, everything reads zero
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_zero: assert (status == '0 && saved_pc == '0 && !irq)
            else $error("a_r1_reset_zero");
      end
   end

   a_r2_crt_records: assert property (@(posedge clk) disable iff (!rst_n)
      (cret_exec && dbg_ctl_q[CTL_CRT_EN]) |=> status[BIT_CRT]);

   a_r3_imprecise: assert property (@(posedge clk) disable iff (!rst_n)
      (cret_exec && dbg_ctl_q[CTL_CRT_EN] && !dbg_en) |=> status[BIT_IMP]);

   a_r4_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cret_exec && dbg_ctl_q[CTL_CRT_EN] && dbg_en) |=> (saved_pc == $past(cret_pc)));

   a_r4_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cret_exec && dbg_ctl_q[CTL_CRT_EN] && dbg_en) |=> $stable(saved_pc));

   a_r7_pmi_records: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_event && pm_en_q) |=> status[BIT_PMI]);

   a_r8_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~status & $past(status))) |-> $past(wr_en && wr_sel == SEL_STATUS));

   a_r9_dbgctl_owned: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_DBGCTL && ext_dbg_mode && !own_mask[OWN_DBGCTL])
      |=> $stable(dbg_ctl_q));

   a_r9_pmctl_owned: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_PMCTL && ext_dbg_mode && !own_mask[OWN_PMCTL])
      |=> $stable(pm_en_q));

   a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (dbg_en && !hi_pri_pend && (status != '0)));

   a_r10_ude_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_en && !hi_pri_pend && status[BIT_UDE]) |-> irq);

endmodule

bind dbg_event_recorder dbg_event_recorder_chk #(
   .N_EXT  (N_EXT),
   .PC_W   (PC_W),
   .STAT_W (STAT_W),
   .CTL_W  (CTL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dbg_en       (dbg_en),
   .hi_pri_pend  (hi_pri_pend),
   .cret_exec    (cret_exec),
   .cret_pc      (cret_pc),
   .pm_event     (pm_event),
   .ext_dbg_mode (ext_dbg_mode),
   .own_mask     (own_mask),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .status       (status),
   .irq          (irq),
   .saved_pc     (saved_pc),
   .dbg_ctl_q    (dbg_ctl_q),
   .pm_en_q      (pm_en_q)
);

// File: tb/dbg_event_recorder_bench.sv
module dbg_event_recorder_bench;

   localparam int CLK_P  = 10;
   localparam int N_EXT  = 2;
   localparam int PC_W   = 32;
   localparam int STAT_W = 4 + N_EXT;
   localparam int LAT    = 2;
   localparam int WD_CYC = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dbg_en = 1'b0;
   logic              hi_pri_pend = 1'b0;
   logic              cret_exec = 1'b0;
   logic [PC_W-1:0]   cret_pc = '0;
   logic [N_EXT-1:0]  ext_evt_pin = '0;
   logic              ude_pin = 1'b0;
   logic              pm_event = 1'b0;
   logic              cpu_stopped = 1'b0;
   logic              ext_dbg_mode = 1'b0;
   logic [1:0]        own_mask = 2'b00;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_sel = 2'd3;
   logic [STAT_W-1:0] wr_data = '0;
   logic [STAT_W-1:0] status;
   logic              irq;
   logic [PC_W-1:0]   saved_pc;

   dbg_event_recorder #(
      .N_EXT       (N_EXT),
      .PC_W        (PC_W),
      .SYNC_STAGES (2)
   ) u_dbg_event_recorder (
      .clk          (clk),
      .rst_n        (rst_n),
      .dbg_en       (dbg_en),
      .hi_pri_pend  (hi_pri_pend),
      .cret_exec    (cret_exec),
      .cret_pc      (cret_pc),
      .ext_evt_pin  (ext_evt_pin),
      .ude_pin      (ude_pin),
      .pm_event     (pm_event),
      .cpu_stopped  (cpu_stopped),
      .ext_dbg_mode (ext_dbg_mode),
      .own_mask     (own_mask),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .status       (status),
      .irq          (irq),
      .saved_pc     (saved_pc)
   );

   always #(CLK_P/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int m_status;
   int m_ctl;
   int m_pm;
   longint m_saved;
   bit m_valid = 0;
   bit ext_hist[N_EXT][$];
   bit ude_hist[$];

   function automatic bit saw_rise(ref bit h[$]);
      if (h.size() < LAT + 2) return 0;
      return h[h.size()-1-LAT] && !h[h.size()-2-LAT];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_status = 0; m_ctl = 0; m_pm = 0; m_saved = 0; m_valid = 1;
         ude_hist.delete();
         for (int i = 0; i < N_EXT; i++) ext_hist[i].delete();
      end else begin
         int setv;
         setv = 0;
         ude_hist.push_back(ude_pin);
         if (ude_hist.size() > 8) void'(ude_hist.pop_front());
         if (saw_rise(ude_hist)) setv |= 2;
         for (int i = 0; i < N_EXT; i++) begin
            ext_hist[i].push_back(ext_evt_pin[i]);
            if (ext_hist[i].size() > 8) void'(ext_hist[i].pop_front());
            if (saw_rise(ext_hist[i]) && m_ctl[1+i] && !cpu_stopped) setv |= (1 << (4+i));
         end
         if (cret_exec && m_ctl[0]) begin
            setv |= 1;
            if (!dbg_en) setv |= 8;
            else m_saved = cret_pc;
         end
         if (pm_event && m_pm != 0) setv |= 4;
         if (wr_en && wr_sel == 2'd2) m_status &= ~int'(wr_data);
         m_status |= setv;
         if (wr_en && wr_sel == 2'd0 && (!ext_dbg_mode || own_mask[0])) m_ctl = int'(wr_data) & 7;
         if (wr_en && wr_sel == 2'd1 && (!ext_dbg_mode || own_mask[1])) m_pm = int'(wr_data[0]);
      end
   end

   // compare every cycle, a quarter period after the edge
   always @(posedge clk) begin
      #(CLK_P/4);
      if (m_valid) begin
         int mask;
         bit exp_irq;
         mask = (m_ctl & 1) | 2 | (m_pm != 0 ? 4 : 0) | (((m_ctl >> 1) & 3) << 4);
         exp_irq = dbg_en && !hi_pri_pend && ((m_status & mask) != 0);
         chk("status model R2/R3/R5/R6/R7/R8/R9", 64'(status), 64'(m_status));
         chk("saved_pc model R4", 64'(saved_pc), 64'(m_saved));
         chk("irq model R10", 64'(irq), 64'(exp_irq));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic sw_write(input logic [1:0] sel, input logic [STAT_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
   endtask

   task automatic cret(input logic [PC_W-1:0] pc);
      @(negedge clk);
      cret_exec = 1'b1; cret_pc = pc;
      @(negedge clk);
      cret_exec = 1'b0;
   endtask

   task automatic pm_pulse();
      @(negedge clk);
      pm_event = 1'b1;
      @(negedge clk);
      pm_event = 1'b0;
   endtask

   task automatic clear_all();
      sw_write(2'd2, '1);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      #1;
      chk("R1 status in reset", 64'(status), 0);
      chk("R1 irq in reset", 64'(irq), 0);
      chk("R1 saved_pc in reset", 64'(saved_pc), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // enable everything
      sw_write(2'd0, 6'b000111);
      sw_write(2'd1, 6'b000001);

      // critical return with interrupts off
      dbg_en = 1'b0;
      cret(32'h100);
      #1;
      chk("R2/R3 crt + imprecise", 64'(status), 64'h09);
      chk("R4 no load with enable off", 64'(saved_pc), 0);
      chk("R10 irq off when disabled", 64'(irq), 0);
      clear_all();
      #1;
      chk("R8 clear all", 64'(status), 0);

      // critical return with interrupts on
      dbg_en = 1'b1;
      cret(32'h2A0);
      #1;
      chk("R3 no imprecise when enabled", 64'(status), 64'h01);
      chk("R4 saved address", 64'(saved_pc), 64'h2A0);
      chk("R10 irq raised", 64'(irq), 1);
      hi_pri_pend = 1'b1;
      #1;
      chk("R10 higher priority masks", 64'(irq), 0);
      hi_pri_pend = 1'b0;
      clear_all();

      // crt disabled
      sw_write(2'd0, 6'b000110);
      cret(32'h444);
      #1;
      chk("R2 crt disabled", 64'(status), 0);
      chk("R4 saved unchanged", 64'(saved_pc), 64'h2A0);

      // external pin 0
      @(negedge clk);
      ext_evt_pin[0] = 1'b1;
      idle(4);
      #1;
      chk("R5 ext0 recorded", 64'(status), 64'h10);
      clear_all();
      idle(5);
      #1;
      chk("R5 held pin no retrigger", 64'(status), 0);
      ext_evt_pin[0] = 1'b0;
      idle(3);

      // external pin 1 while stopped
      cpu_stopped = 1'b1;
      @(negedge clk);
      ext_evt_pin[1] = 1'b1;
      idle(5);
      cpu_stopped = 1'b0;
      idle(3);
      #1;
      chk("R5 stopped drops edge", 64'(status), 0);
      ext_evt_pin[1] = 1'b0;
      idle(3);

      // unconditional pin with no enables at all
      sw_write(2'd0, 6'b000000);
      @(negedge clk);
      ude_pin = 1'b1;
      idle(4);
      #1;
      chk("R6 unconditional recorded", 64'(status), 64'h02);
      chk("R10 unconditional drives irq", 64'(irq), 1);
      ude_pin = 1'b0;
      idle(3);
      clear_all();

      // performance monitor
      pm_pulse();
      #1;
      chk("R7 pmi recorded", 64'(status), 64'h04);
      clear_all();
      sw_write(2'd1, 6'b000000);
      pm_pulse();
      #1;
      chk("R7 pmi disabled", 64'(status), 0);

      // event wins over clear
      sw_write(2'd1, 6'b000001);
      pm_pulse();
      @(negedge clk);
      pm_event = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 6'h04;
      @(negedge clk);
      pm_event = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
      #1;
      chk("R8 event beats clear", 64'(status), 64'h04);
      clear_all();
      #1;
      chk("R8 clear alone", 64'(status), 0);

      // ownership
      ext_dbg_mode = 1'b1;
      own_mask = 2'b00;
      sw_write(2'd0, 6'b000001);
      cret(32'h500);
      #1;
      chk("R9 owned dbgctl write ignored", 64'(status), 0);
      pm_pulse();
      sw_write(2'd2, 6'h04);
      #1;
      chk("R9 status write accepted", 64'(status), 0);
      sw_write(2'd1, 6'b000000);
      pm_pulse();
      #1;
      chk("R9 owned pmctl write ignored", 64'(status), 64'h04);
      clear_all();
      own_mask = 2'b01;
      sw_write(2'd0, 6'b000001);
      cret(32'h55C);
      #1;
      chk("R9 released dbgctl write taken", 64'(status), 64'h01);
      chk("R9 released saved address", 64'(saved_pc), 64'h55C);
      ext_dbg_mode = 1'b0;
      own_mask = 2'b00;

      dbg_en = 1'b0;
      #1;
      chk("R10 irq follows enable low", 64'(irq), 0);
      dbg_en = 1'b1;
      #1;
      chk("R10 irq follows enable high", 64'(irq), 1);

      idle(3);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule